// File: doc/BRIEF.md
# Next-PC and Branch Unit

This block holds the program counter of a 32-bit RISC core whose instructions are all one word long and word aligned. Each time the decode stage presents a valid instruction, the block works out where execution goes next. The choices are the following word, a PC-relative branch (conditional or unconditional), an absolute jump inside the current 256 MB region, or a jump through a register value. It also asks for a write of the return address when the instruction is a call.

Jumps through a register are checked for word alignment. A misaligned target does not redirect the PC. Instead the block raises an exception request, carrying the faulting target as the bad address and the PC already advanced past the faulting instruction. Fetch, the register file and exception vectoring sit outside. The block only reports the exception and the address.

Link-write and exception outputs are combinational from the current inputs while `step` is high. The PC register changes on the rising clock edge where `step` is high.

Top module: `nextpc_unit`

## Requirements
- R1: While `rst_n` is low the PC register loads `RESET_VEC` (default 32'h0000_1000), and `link_we` and `exc_req` are 0.
- R2: With `step` low the PC keeps its value and `link_we` and `exc_req` stay 0, whatever the other inputs are.
- R3: Class code 0 (sequential) advances the PC by 4. The unused codes 13, 14 and 15 behave exactly like code 0.
- R4: A relative target is (PC+4) plus the sign-extended 16-bit immediate with its bits [1:0] forced to zero. Class code 7 takes this target unconditionally.
- R5: Class codes 1 to 6 compare operands A and B and take the relative target when the condition holds, else PC+4. The conditions are: 1 A==B, 2 A!=B, 3 signed A>=B, 4 signed A<B, 5 unsigned A>=B, 6 unsigned A<B.
- R6: Class codes 8 (jump) and 9 (call) go to {PC[31:28], imm26, 2'b00}.
- R7: Class codes 9 (call) and 11 (register call) raise `link_we` with `link_data` = PC+4, unless R9 applies.
- R8: Class codes 10 (register jump), 11 (register call) and 12 (return) go to operand A when A[1:0] is 0. For a return, operand A carries the return-address register.
- R9: For codes 10 to 12 with A[1:0] nonzero, the block does not jump and writes no link. It raises `exc_req` with `exc_badaddr` = A and `exc_pc` = PC+4, and the PC becomes PC+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | Instruction valid; the PC updates on this edge |
| op | input | 4 | Instruction class code (see R3 to R9) |
| imm16 | input | 16 | Relative branch immediate |
| imm26 | input | 26 | Absolute jump immediate |
| opa | input | 32 | Operand A (compare operand or register target) |
| opb | input | 32 | Operand B (compare operand) |
| pc | output | 32 | Current program counter |
| link_we | output | 1 | Return-address write request |
| link_data | output | 32 | Return address (PC+4) |
| exc_req | output | 1 | Misaligned register-target exception |
| exc_badaddr | output | 32 | Faulting target address |
| exc_pc | output | 32 | PC reported with the exception (already advanced) |

## Verification
The absolute-jump case needs a PC with nonzero upper four bits, and the unit only starts low in memory. So the vector walk first uses an aligned register jump to move into the 0xA000_0000 region. It then issues jump and call there, so the region bits are seen to survive. A call placed at the very top of that region gives a link value that carries into bit 28. Misaligned register jump and call follow back to back, which shows that the PC still advances, the link stays quiet and the bad address tracks operand A.

// File: rtl/nextpc_unit.sv
module nextpc_unit #(
  parameter int          XLEN      = 32,
  parameter logic [31:0] RESET_VEC = 32'h0000_1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        step,
  input  logic [3:0]  op,
  input  logic [15:0] imm16,
  input  logic [25:0] imm26,
  input  logic [31:0] opa,
  input  logic [31:0] opb,
  output logic [31:0] pc,
  output logic        link_we,
  output logic [31:0] link_data,
  output logic        exc_req,
  output logic [31:0] exc_badaddr,
  output logic [31:0] exc_pc
);
  localparam int REGION_W = 4;

  localparam logic [3:0] C_SEQ  = 4'd0;
  localparam logic [3:0] C_BEQ  = 4'd1;
  localparam logic [3:0] C_BNE  = 4'd2;
  localparam logic [3:0] C_BGE  = 4'd3;
  localparam logic [3:0] C_BLT  = 4'd4;
  localparam logic [3:0] C_BGEU = 4'd5;
  localparam logic [3:0] C_BLTU = 4'd6;
  localparam logic [3:0] C_BR   = 4'd7;
  localparam logic [3:0] C_JMPI = 4'd8;
  localparam logic [3:0] C_CALL = 4'd9;
  localparam logic [3:0] C_JMPR = 4'd10;
  localparam logic [3:0] C_CALR = 4'd11;
  localparam logic [3:0] C_RET  = 4'd12;

  logic [XLEN-1:0] pc_q, pc_d, seq_pc, rel_pc, abs_pc;
  logic            taken, is_reg, misal;

  assign seq_pc = pc_q + 32'd4;
  assign rel_pc = seq_pc + {{(XLEN-16){imm16[15]}}, imm16[15:2], 2'b00};
  assign abs_pc = {pc_q[XLEN-1 -: REGION_W], imm26, 2'b00};
  assign is_reg = (op == C_JMPR) || (op == C_CALR) || (op == C_RET);
  assign misal  = |opa[1:0];

  always_comb begin
    unique case (op)
      C_BEQ:   taken = (opa == opb);
      C_BNE:   taken = (opa != opb);
      C_BGE:   taken = ($signed(opa) >= $signed(opb));
      C_BLT:   taken = ($signed(opa) <  $signed(opb));
      C_BGEU:  taken = (opa >= opb);
      C_BLTU:  taken = (opa <  opb);
      C_BR:    taken = 1'b1;
      default: taken = 1'b0;
    endcase
  end

  always_comb begin
    pc_d = seq_pc;
    if (op == C_JMPI || op == C_CALL) pc_d = abs_pc;
    else if (is_reg)                  pc_d = misal ? seq_pc : opa;
    else if (taken)                   pc_d = rel_pc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    pc_q <= RESET_VEC;
    else if (step) pc_q <= pc_d;
  end

  assign pc          = pc_q;
  assign link_data   = seq_pc;
  assign link_we     = rst_n && step &&
                       ((op == C_CALL) || ((op == C_CALR) && !misal));
  assign exc_req     = rst_n && step && is_reg && misal;
  assign exc_badaddr = opa;
  assign exc_pc      = seq_pc;

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(pc));
  a_r3_seq: assert property (@(posedge clk) disable iff (!rst_n)
    (step && op == C_SEQ) |=> (pc == $past(pc) + 32'd4));
  a_r6_region: assert property (@(posedge clk) disable iff (!rst_n)
    (step && (op == C_JMPI || op == C_CALL)) |=> (pc[31:28] == $past(pc[31:28])));
  a_r8_target: assert property (@(posedge clk) disable iff (!rst_n)
    (step && is_reg && !misal) |=> (pc == $past(opa)));
  a_r9_nolink: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> !link_we);
  a_r9_bad: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> (exc_badaddr[1:0] != 2'b00));
  a_r9_adv: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |=> (pc == $past(exc_pc)));
endmodule

// File: tb/test_nextpc_unit.sv
`timescale 1ns/1ps
module test_nextpc_unit;
  localparam logic [31:0] RV = 32'h0000_1000;
  localparam int NV = 20;

  logic clk = 0, rst_n = 0, step = 0;
  logic [3:0] op = 0;
  logic [15:0] imm16 = 0;
  logic [25:0] imm26 = 0;
  logic [31:0] opa = 0, opb = 0;
  logic [31:0] pc, link_data, exc_badaddr, exc_pc;
  logic link_we, exc_req;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  nextpc_unit #(.RESET_VEC(RV)) i_nextpc_unit (
    .clk(clk), .rst_n(rst_n), .step(step), .op(op), .imm16(imm16),
    .imm26(imm26), .opa(opa), .opb(opb), .pc(pc), .link_we(link_we),
    .link_data(link_data), .exc_req(exc_req), .exc_badaddr(exc_badaddr),
    .exc_pc(exc_pc));

  // {op, imm16, imm26, a, b, next pc, link, exc}
  localparam logic [143:0] TBL [0:NV-1] = '{
    {4'd0,  16'h0000, 26'h0,       32'h0,        32'h0,        32'h0000_1004, 1'b0, 1'b0},
    {4'd1,  16'h0010, 26'h0,       32'h5,        32'h5,        32'h0000_1018, 1'b0, 1'b0},
    {4'd2,  16'h0100, 26'h0,       32'h5,        32'h5,        32'h0000_101C, 1'b0, 1'b0},
    {4'd3,  16'h0100, 26'h0,       32'hFFFF_FFFF,32'h1,        32'h0000_1020, 1'b0, 1'b0},
    {4'd4,  16'hFFF3, 26'h0,       32'hFFFF_FFFF,32'h1,        32'h0000_1014, 1'b0, 1'b0},
    {4'd5,  16'h0022, 26'h0,       32'hFFFF_FFFF,32'h1,        32'h0000_1038, 1'b0, 1'b0},
    {4'd6,  16'h0100, 26'h0,       32'hFFFF_FFFF,32'h1,        32'h0000_103C, 1'b0, 1'b0},
    {4'd7,  16'h0007, 26'h0,       32'h0,        32'h0,        32'h0000_1044, 1'b0, 1'b0},
    {4'd10, 16'h0000, 26'h0,       32'hA000_0010,32'h0,        32'hA000_0010, 1'b0, 1'b0},
    {4'd8,  16'h0000, 26'h100,     32'h0,        32'h0,        32'hA000_0400, 1'b0, 1'b0},
    {4'd9,  16'h0000, 26'h3FF_FFFF,32'h0,        32'h0,        32'hAFFF_FFFC, 1'b1, 1'b0},
    {4'd11, 16'h0000, 26'h0,       32'h0000_2000,32'h0,        32'h0000_2000, 1'b1, 1'b0},
    {4'd12, 16'h0000, 26'h0,       32'h0000_3000,32'h0,        32'h0000_3000, 1'b0, 1'b0},
    {4'd10, 16'h0000, 26'h0,       32'h0000_4002,32'h0,        32'h0000_3004, 1'b0, 1'b1},
    {4'd11, 16'h0000, 26'h0,       32'h0000_5001,32'h0,        32'h0000_3008, 1'b0, 1'b1},
    {4'd1,  16'h0040, 26'h0,       32'h1,        32'h2,        32'h0000_300C, 1'b0, 1'b0},
    {4'd4,  16'h0040, 26'h0,       32'h1,        32'hFFFF_FFFF,32'h0000_3010, 1'b0, 1'b0},
    {4'd6,  16'h0008, 26'h0,       32'h1,        32'hFFFF_FFFF,32'h0000_301C, 1'b0, 1'b0},
    {4'd3,  16'h0004, 26'h0,       32'h3,        32'h3,        32'h0000_3024, 1'b0, 1'b0},
    {4'd2,  16'hFFFC, 26'h0,       32'h3,        32'h4,        32'h0000_3024, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] prev;
    repeat (3) @(negedge clk);
    chk("R1 reset pc", pc, RV);
    chk("R1 reset link", {31'b0, link_we}, 0);
    chk("R1 reset exc", {31'b0, exc_req}, 0);
    rst_n = 1;
    @(negedge clk);
    // R2: idle step with a misaligned register call on the inputs
    op = 4'd11; opa = 32'h0000_7003;
    #1;
    chk("R2 idle link", {31'b0, link_we}, 0);
    chk("R2 idle exc", {31'b0, exc_req}, 0);
    @(negedge clk);
    chk("R2 idle pc", pc, RV);

    prev = RV;
    for (int k = 0; k < NV; k++) begin
      logic [143:0] v;
      v = TBL[k];
      op = v[143:140]; imm16 = v[139:124]; imm26 = v[123:98];
      opa = v[97:66]; opb = v[65:34]; step = 1;
      #1;
      chk($sformatf("R4/R5/R6/R7/R8/R9 link_we v%0d", k), {31'b0, link_we}, {31'b0, v[1]});
      chk($sformatf("R9 exc_req v%0d", k), {31'b0, exc_req}, {31'b0, v[0]});
      if (v[1]) chk($sformatf("R7 link_data v%0d", k), link_data, prev + 32'd4);
      if (v[0]) begin
        chk($sformatf("R9 badaddr v%0d", k), exc_badaddr, v[97:66]);
        chk($sformatf("R9 exc_pc v%0d", k), exc_pc, prev + 32'd4);
      end
      @(negedge clk);
      chk($sformatf("R3/R4/R5/R6/R8 next pc v%0d", k), pc, v[33:2]);
      prev = v[33:2];
    end

    // R3: unused class codes act as sequential
    for (int c = 13; c < 16; c++) begin
      op = c[3:0]; opa = 32'h0000_0001; imm16 = 16'h0100; imm26 = 26'h5;
      #1;
      chk("R3 unused code link", {31'b0, link_we | exc_req}, 0);
      @(negedge clk);
      chk("R3 unused code pc", pc, prev + 32'd4);
      prev = prev + 32'd4;
    end

    // R1: reset in mid run
    step = 0; rst_n = 0;
    @(negedge clk);
    chk("R1 mid-run reset pc", pc, RV);
    rst_n = 1;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule